// File: doc/BRIEF.md
# Host Adapter Doorbell Register Interface

This block is the adapter-side register file that a host processor sees through a 16-byte I/O window. It holds two doorbell pairs. One pair runs from host to adapter: a local mask and a local status/command byte. The other pair runs from adapter to host: a host mask and a host status byte. The window also holds a read-only product identifier, two configuration bytes, and two 32-bit mailbox pointers. The outgoing pointer is written by the host. The incoming pointer is loaded by the adapter.

The host hands work to the adapter by writing the outgoing pointer and then setting the outgoing-mail bit. Firmware sees that bit as a request and clears it with an acknowledge strobe. Reset requests work the same way: the bit stays set until firmware reports that the reset is done. In the other direction, firmware posts incoming mail by strobing a pointer into the block. This is accepted only while the previous mail has been released. The host releases it by writing 1 to the mail bit. The host interrupt line is a registered OR of each host status bit gated by its enable.

Top module: `hdb_doorbell_regs`

## Requirements
- R1: After synchronous reset: local mask reads 0xE1; local status, host mask and host status read 0x00; both pointers read 0; host_irq is 0; adp_ready is 1.
- R2: Offset 4 reads 0x56. Offset 5 reads 0x40, or 0x41 when VARIANT=1. Offset 6 reads {DMA_SEL[1:0], IRQ_SEL[1:0], 4'b0}. Offset 7 reads {5'b0, OWN_ID[2:0]}. Host writes to offsets 4–7 have no effect.
- R3: A host write to offset 1 sets bit 0 (outgoing mail) only if local mask bit 0 is 1, sets bit 6 (soft reset) only if local mask bit 6 is 1, and always sets bit 5 (bus reset). Writing 0 clears nothing. The other bits read 0.
- R4: fw_ogm_ack clears bit 0 of offset 1. fw_bus_rst_done clears bit 5. fw_soft_rst_done clears bit 6. When a host set and a firmware clear of the same bit fall in one cycle, the bit ends up set.
- R5: Offset 3 holds bit 0 (incoming mail) and bit 7 (pending). Writing 1 to a bit clears it, and writing 0 leaves it unchanged. Offset 2 stores only bits 0 and 7; the other bits read 0.
- R6: fw_icm_post is accepted only while offset 3 bit 0 is 0. An accepted post loads fw_icm_ptr into offsets 12–15 and sets bit 0. A rejected post changes nothing. fw_icm_ready equals the inverse of offset 3 bit 0.
- R7: fw_pend_raise sets offset 3 bit 7. If the host clears bit 7 in the same cycle, the bit still ends up set.
- R8: host_irq, in each cycle, equals (status bit 0 AND mask bit 0) OR (status bit 7 AND mask bit 7), using the register values of the previous cycle.
- R9: Offsets 8–11 hold the outgoing pointer in little-endian order (offset 8 holds bits 7:0). Each byte is writable on its own and readable, and the pointer drives fw_ogm_ptr. Host writes to offsets 12–15 have no effect.
- R10: adp_ready is 1 exactly when all bits of local mask & 0xE1 are set. The local mask is a fully writable byte.
- R11: When bus_rd is 1 at a clock edge, bus_rdata takes the byte at bus_addr as it stood before that edge. When bus_rd is 0, bus_rdata holds its value.
- R12: fw_ogm_req, fw_bus_rst_req and fw_soft_rst_req show bits 0, 5 and 6 of offset 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_wr | input | 1 | Host write strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rd | input | 1 | Host read strobe |
| bus_rdata | output | 8 | Registered read data |
| host_irq | output | 1 | Interrupt to host |
| adp_ready | output | 1 | All ready mask bits are set |
| fw_ogm_req | output | 1 | Outgoing mail waiting |
| fw_bus_rst_req | output | 1 | Bus reset requested |
| fw_soft_rst_req | output | 1 | Soft reset requested |
| fw_ogm_ptr | output | PTR_W | Outgoing mailbox pointer |
| fw_ogm_ack | input | 1 | Firmware took the outgoing mail |
| fw_bus_rst_done | input | 1 | Bus reset finished |
| fw_soft_rst_done | input | 1 | Soft reset finished |
| fw_icm_post | input | 1 | Firmware posts incoming mail |
| fw_icm_ptr | input | PTR_W | Pointer of posted mail |
| fw_icm_ready | output | 1 | Incoming slot free |
| fw_pend_raise | input | 1 | Set the pending bit |

## Verification
The bench goes after cycles where both sides touch the same bit. An ack and a host set together must leave the request standing; a design where the clear wins would lose a doorbell. A raise together with a write-1 clear must leave the pending bit set, or an interrupt would be lost. A post while the slot is full must leave the incoming pointer alone; a design that ignores the busy slot would overwrite mail the host has not yet read. The bench also checks the mask-gated setting of the reset and mail bits, the one-cycle lag of the interrupt behind a mask change, and writes to read-only bytes, where a wrong decode would corrupt the identifier or the incoming pointer.

// File: rtl/hdb_pkg.sv
package hdb_pkg;
  localparam int OFS_LMASK = 0;
  localparam int OFS_LSTAT = 1;
  localparam int OFS_HMASK = 2;
  localparam int OFS_HSTAT = 3;
  localparam int OFS_PID0  = 4;
  localparam int OFS_PID1  = 5;
  localparam int OFS_CFG1  = 6;
  localparam int OFS_CFG2  = 7;
  localparam int OGM_BASE  = 8;

  // local status bit positions
  localparam int LS_OGM  = 0;
  localparam int LS_BUS  = 5;
  localparam int LS_SOFT = 6;
  // host status / host mask bit positions
  localparam int HS_MAIL = 0;
  localparam int HS_PEND = 7;

  localparam logic [7:0] LMASK_READY = 8'hE1;
  localparam logic [7:0] LMASK_INIT  = 8'hE1;
  localparam logic [7:0] PID_LO      = 8'h56;
  localparam logic [7:0] PID_HI_A    = 8'h40;
  localparam logic [7:0] PID_HI_B    = 8'h41;
endpackage

// File: rtl/hdb_sticky_bits.sv
// Bits set by one side and cleared by the other; set has priority.
module hdb_sticky_bits #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           q[i] <= 1'b0;
      else if (set_i[i]) q[i] <= 1'b1;
      else if (clr_i[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/hdb_ptr_reg.sv
// Pointer register with byte lanes: host byte writes or a full parallel load.
module hdb_ptr_reg #(
  parameter int PTR_W   = 32,
  parameter int ADDR_W  = 4,
  parameter int BASE    = 8,
  parameter bit HOST_WR = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              load,
  input  logic [PTR_W-1:0]  load_val,
  output logic [PTR_W-1:0]  q
);
  localparam int NBYTES = PTR_W / 8;

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    logic lane_hit;
    assign lane_hit = HOST_WR && wr_en && (wr_addr == ADDR_W'(BASE + i));
    always_ff @(posedge clk) begin
      if (rst)           q[8*i +: 8] <= 8'h00;
      else if (load)     q[8*i +: 8] <= load_val[8*i +: 8];
      else if (lane_hit) q[8*i +: 8] <= wr_data;
    end
  end
endmodule

// File: rtl/hdb_host_side.sv
// Host doorbell: post gating, write-1-to-clear, registered interrupt.
module hdb_host_side (
  input  logic       clk,
  input  logic       rst,
  input  logic       post_i,
  input  logic       raise_i,
  input  logic       clr_mail_i,
  input  logic       clr_pend_i,
  input  logic       en_mail_i,
  input  logic       en_pend_i,
  output logic       post_ok_o,
  output logic       mail_o,
  output logic       pend_o,
  output logic       irq_o
);
  logic [1:0] st;

  assign post_ok_o = post_i && !st[0];

  hdb_sticky_bits #(.N(2)) u_st (
    .clk   (clk),
    .rst   (rst),
    .set_i ({raise_i, post_ok_o}),
    .clr_i ({clr_pend_i, clr_mail_i}),
    .q     (st)
  );

  assign mail_o = st[0];
  assign pend_o = st[1];

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= (st[0] && en_mail_i) || (st[1] && en_pend_i);
  end
endmodule

// File: rtl/hdb_doorbell_regs.sv
module hdb_doorbell_regs #(
  parameter int ADDR_W  = 4,
  parameter int PTR_W   = 32,
  parameter bit VARIANT = 1'b0,
  parameter int IRQ_SEL = 1,
  parameter int DMA_SEL = 0,
  parameter int OWN_ID  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  output logic              host_irq,
  output logic              adp_ready,
  output logic              fw_ogm_req,
  output logic              fw_bus_rst_req,
  output logic              fw_soft_rst_req,
  output logic [PTR_W-1:0]  fw_ogm_ptr,
  input  logic              fw_ogm_ack,
  input  logic              fw_bus_rst_done,
  input  logic              fw_soft_rst_done,
  input  logic              fw_icm_post,
  input  logic [PTR_W-1:0]  fw_icm_ptr,
  output logic              fw_icm_ready,
  input  logic              fw_pend_raise
);
  import hdb_pkg::*;

  localparam int PTR_BYTES = PTR_W / 8;
  localparam int ICM_BASE  = OGM_BASE + PTR_BYTES;
  localparam logic [7:0] PID_HI = VARIANT ? PID_HI_B : PID_HI_A;
  localparam logic [7:0] CFG1   = {2'(DMA_SEL), 2'(IRQ_SEL), 4'b0000};
  localparam logic [7:0] CFG2   = {5'b00000, 3'(OWN_ID)};

  logic [7:0]       lmask_q;
  logic [1:0]       hmask_q;
  logic [2:0]       lst;
  logic [PTR_W-1:0] ogm_q;
  logic [PTR_W-1:0] icm_q;
  logic             hs_mail, hs_pend, post_ok;
  logic [7:0]       rd_mux;

  logic wr_lmask, wr_lstat, wr_hmask, wr_hstat;
  assign wr_lmask = bus_wr && (bus_addr == ADDR_W'(OFS_LMASK));
  assign wr_lstat = bus_wr && (bus_addr == ADDR_W'(OFS_LSTAT));
  assign wr_hmask = bus_wr && (bus_addr == ADDR_W'(OFS_HMASK));
  assign wr_hstat = bus_wr && (bus_addr == ADDR_W'(OFS_HSTAT));

  always_ff @(posedge clk) begin
    if (rst) begin
      lmask_q <= LMASK_INIT;
      hmask_q <= 2'b00;
    end else begin
      if (wr_lmask) lmask_q <= bus_wdata;
      if (wr_hmask) hmask_q <= {bus_wdata[HS_PEND], bus_wdata[HS_MAIL]};
    end
  end

  // local doorbell: {soft, bus, ogm}
  logic [2:0] lst_set, lst_clr;
  assign lst_set = {wr_lstat && bus_wdata[LS_SOFT] && lmask_q[LS_SOFT],
                    wr_lstat && bus_wdata[LS_BUS],
                    wr_lstat && bus_wdata[LS_OGM] && lmask_q[LS_OGM]};
  assign lst_clr = {fw_soft_rst_done, fw_bus_rst_done, fw_ogm_ack};

  hdb_sticky_bits #(.N(3)) u_local (
    .clk   (clk),
    .rst   (rst),
    .set_i (lst_set),
    .clr_i (lst_clr),
    .q     (lst)
  );

  hdb_host_side u_host (
    .clk        (clk),
    .rst        (rst),
    .post_i     (fw_icm_post),
    .raise_i    (fw_pend_raise),
    .clr_mail_i (wr_hstat && bus_wdata[HS_MAIL]),
    .clr_pend_i (wr_hstat && bus_wdata[HS_PEND]),
    .en_mail_i  (hmask_q[0]),
    .en_pend_i  (hmask_q[1]),
    .post_ok_o  (post_ok),
    .mail_o     (hs_mail),
    .pend_o     (hs_pend),
    .irq_o      (host_irq)
  );

  hdb_ptr_reg #(.PTR_W(PTR_W), .ADDR_W(ADDR_W), .BASE(OGM_BASE), .HOST_WR(1'b1)) u_ogm (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (bus_wr),
    .wr_addr  (bus_addr),
    .wr_data  (bus_wdata),
    .load     (1'b0),
    .load_val ({PTR_W{1'b0}}),
    .q        (ogm_q)
  );

  hdb_ptr_reg #(.PTR_W(PTR_W), .ADDR_W(ADDR_W), .BASE(ICM_BASE), .HOST_WR(1'b0)) u_icm (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (bus_wr),
    .wr_addr  (bus_addr),
    .wr_data  (bus_wdata),
    .load     (post_ok),
    .load_val (fw_icm_ptr),
    .q        (icm_q)
  );

  always_comb begin
    rd_mux = 8'h00;
    if (bus_addr == ADDR_W'(OFS_LMASK)) rd_mux = lmask_q;
    if (bus_addr == ADDR_W'(OFS_LSTAT)) rd_mux = {1'b0, lst[2], lst[1], 4'b0000, lst[0]};
    if (bus_addr == ADDR_W'(OFS_HMASK)) rd_mux = {hmask_q[1], 6'b000000, hmask_q[0]};
    if (bus_addr == ADDR_W'(OFS_HSTAT)) rd_mux = {hs_pend, 6'b000000, hs_mail};
    if (bus_addr == ADDR_W'(OFS_PID0))  rd_mux = PID_LO;
    if (bus_addr == ADDR_W'(OFS_PID1))  rd_mux = PID_HI;
    if (bus_addr == ADDR_W'(OFS_CFG1))  rd_mux = CFG1;
    if (bus_addr == ADDR_W'(OFS_CFG2))  rd_mux = CFG2;
    for (int i = 0; i < PTR_BYTES; i++) begin
      if (bus_addr == ADDR_W'(OGM_BASE + i)) rd_mux = ogm_q[8*i +: 8];
      if (bus_addr == ADDR_W'(ICM_BASE + i)) rd_mux = icm_q[8*i +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= 8'h00;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign adp_ready       = (lmask_q & LMASK_READY) == LMASK_READY;
  assign fw_ogm_req      = lst[0];
  assign fw_bus_rst_req  = lst[1];
  assign fw_soft_rst_req = lst[2];
  assign fw_ogm_ptr      = ogm_q;
  assign fw_icm_ready    = !hs_mail;
endmodule

// File: rtl/hdb_doorbell_checker.sv
module hdb_doorbell_checker #(
  parameter int ADDR_W = 4,
  parameter int PTR_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_rdata,
  input logic              host_irq,
  input logic              fw_ogm_req,
  input logic              fw_ogm_ack,
  input logic              fw_soft_rst_req,
  input logic              fw_soft_rst_done,
  input logic              fw_icm_post,
  input logic [PTR_W-1:0]  fw_icm_ptr,
  input logic              fw_icm_ready,
  input logic [PTR_W-1:0]  icm_q,
  input logic              hs_mail,
  input logic              hs_pend,
  input logic [1:0]        hmask_q
);
  p_irq_lag_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> host_irq == $past((hs_mail && hmask_q[0]) || (hs_pend && hmask_q[1])));

  p_post_fills_r6: assert property (@(posedge clk) disable iff (rst)
    (fw_icm_post && fw_icm_ready) |=> (!fw_icm_ready && icm_q == $past(fw_icm_ptr)));

  p_post_blocked_r6: assert property (@(posedge clk) disable iff (rst)
    (fw_icm_post && !fw_icm_ready) |=> $stable(icm_q));

  p_ack_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (fw_ogm_ack && !(bus_wr && bus_addr == ADDR_W'(1))) |=> !fw_ogm_req);

  p_soft_holds_r4: assert property (@(posedge clk) disable iff (rst)
    (fw_soft_rst_req && !fw_soft_rst_done) |=> fw_soft_rst_req);

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind hdb_doorbell_regs hdb_doorbell_checker #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_chk (
  .clk              (clk),
  .rst              (rst),
  .bus_addr         (bus_addr),
  .bus_wr           (bus_wr),
  .bus_rd           (bus_rd),
  .bus_rdata        (bus_rdata),
  .host_irq         (host_irq),
  .fw_ogm_req       (fw_ogm_req),
  .fw_ogm_ack       (fw_ogm_ack),
  .fw_soft_rst_req  (fw_soft_rst_req),
  .fw_soft_rst_done (fw_soft_rst_done),
  .fw_icm_post      (fw_icm_post),
  .fw_icm_ptr       (fw_icm_ptr),
  .fw_icm_ready     (fw_icm_ready),
  .icm_q            (icm_q),
  .hs_mail          (hs_mail),
  .hs_pend          (hs_pend),
  .hmask_q          (hmask_q)
);

// File: tb/hdb_doorbell_regs_test.sv
`timescale 1ns/1ps
module hdb_doorbell_regs_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic        host_irq, adp_ready, fw_ogm_req, fw_bus_rst_req, fw_soft_rst_req;
  logic [31:0] fw_ogm_ptr, fw_icm_ptr = '0;
  logic        fw_ogm_ack = 0, fw_bus_rst_done = 0, fw_soft_rst_done = 0;
  logic        fw_icm_post = 0, fw_icm_ready, fw_pend_raise = 0;

  int n_chk = 0, n_fail = 0;

  // model state
  logic [7:0]  m_lmask, m_ls, m_hmask, m_hs, m_rdata;
  logic [31:0] m_ogm, m_icm;

  always #5 clk = ~clk;

  hdb_doorbell_regs uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .host_irq(host_irq), .adp_ready(adp_ready),
    .fw_ogm_req(fw_ogm_req), .fw_bus_rst_req(fw_bus_rst_req), .fw_soft_rst_req(fw_soft_rst_req),
    .fw_ogm_ptr(fw_ogm_ptr), .fw_ogm_ack(fw_ogm_ack), .fw_bus_rst_done(fw_bus_rst_done),
    .fw_soft_rst_done(fw_soft_rst_done), .fw_icm_post(fw_icm_post), .fw_icm_ptr(fw_icm_ptr),
    .fw_icm_ready(fw_icm_ready), .fw_pend_raise(fw_pend_raise));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_read(input logic [3:0] a);
    case (a)
      4'd0: return m_lmask;
      4'd1: return m_ls;
      4'd2: return m_hmask;
      4'd3: return m_hs;
      4'd4: return 8'h56;
      4'd5: return 8'h40;
      4'd6: return 8'h10;          // DMA_SEL=0, IRQ_SEL=1
      4'd7: return 8'h07;
      4'd8, 4'd9, 4'd10, 4'd11: return m_ogm[8*(a-8) +: 8];
      default: return m_icm[8*(a-12) +: 8];
    endcase
  endfunction

  function automatic void model_reset();
    m_lmask = 8'hE1; m_ls = 8'h00; m_hmask = 8'h00; m_hs = 8'h00;
    m_rdata = 8'h00; m_ogm = '0; m_icm = '0;
  endfunction

  task automatic cycle(input logic wr, input logic [3:0] a, input logic [7:0] d, input logic rd,
                       input logic ack, input logic brd, input logic srd,
                       input logic post, input logic [31:0] p, input logic raise,
                       input string tag);
    logic [7:0] nls, nhs;
    logic       exp_irq;
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; bus_rd = rd;
    fw_ogm_ack = ack; fw_bus_rst_done = brd; fw_soft_rst_done = srd;
    fw_icm_post = post; fw_icm_ptr = p; fw_pend_raise = raise;
    if (rd) m_rdata = model_read(a);
    exp_irq = (m_hs[0] & m_hmask[0]) | (m_hs[7] & m_hmask[7]);
    // local status: clear then set (set wins)
    nls = m_ls;
    if (ack) nls[0] = 1'b0;
    if (brd) nls[5] = 1'b0;
    if (srd) nls[6] = 1'b0;
    if (wr && a == 4'd1) begin
      if (d[0] && m_lmask[0]) nls[0] = 1'b1;
      if (d[5])               nls[5] = 1'b1;
      if (d[6] && m_lmask[6]) nls[6] = 1'b1;
    end
    // host status
    nhs = m_hs;
    if (wr && a == 4'd3) nhs = nhs & ~(d & 8'h81);
    if (post && !m_hs[0]) begin nhs[0] = 1'b1; m_icm = p; end
    if (raise) nhs[7] = 1'b1;
    if (wr && a == 4'd0) m_lmask = d;
    if (wr && a == 4'd2) m_hmask = d & 8'h81;
    if (wr && a >= 4'd8 && a <= 4'd11) m_ogm[8*(a-8) +: 8] = d;
    m_ls = nls; m_hs = nhs;
    @(posedge clk); #1;
    check({tag, " rdata"}, 32'(bus_rdata), 32'(m_rdata));
    check("R8 irq", 32'(host_irq), 32'(exp_irq));
    check("R12 fw req", {29'd0, fw_soft_rst_req, fw_bus_rst_req, fw_ogm_req},
          {29'd0, m_ls[6], m_ls[5], m_ls[0]});
    check("R10 ready", 32'(adp_ready), 32'((m_lmask & 8'hE1) == 8'hE1));
    check("R6 icm ready", 32'(fw_icm_ready), 32'(!m_hs[0]));
    check("R9 ogm ptr", fw_ogm_ptr, m_ogm);
  endtask

  task automatic hw(input logic [3:0] a, input logic [7:0] d, input string tag);
    cycle(1, a, d, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic hr(input logic [3:0] a, input string tag);
    cycle(0, a, 0, 1, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #2_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed);
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 / R2 reset contents and identity bytes
    for (int i = 0; i < 16; i++) hr(4'(i), (i >= 4 && i < 8) ? "R2 id" : "R1 reset");
    // R2 read-only bytes ignore writes, R9 icm ignores host writes
    for (int i = 4; i < 8; i++) begin hw(4'(i), 8'hAA, "R2 wr"); hr(4'(i), "R2 ro"); end
    hw(4'd12, 8'h77, "R9 icm wr"); hr(4'd12, "R9 icm ro");
    // R9 outgoing pointer bytes
    hw(4'd8, 8'h11, "R9"); hw(4'd10, 8'h33, "R9"); hw(4'd11, 8'hC4, "R9"); hr(4'd10, "R9 rd");
    // R3 / R10 mask gating
    hw(4'd0, 8'h00, "R10 mask"); hw(4'd1, 8'h61, "R3 gated"); hr(4'd1, "R3 gated rd");
    cycle(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R4 bus done");
    hw(4'd0, 8'hE1, "R10 mask");
    hw(4'd1, 8'h41, "R3 set"); hw(4'd1, 8'h00, "R3 zero"); hr(4'd1, "R3 hold");
    // R4 ack with simultaneous set: set wins; then clears
    cycle(1, 4'd1, 8'h01, 0, 1, 0, 0, 0, 0, 0, "R4 set wins");
    cycle(0, 0, 0, 1, 1, 0, 1, 0, 0, 0, "R4 clear");
    hr(4'd1, "R4 rd");
    // R6 post, reject, R8 irq with mask, R5 w1c
    cycle(0, 0, 0, 0, 0, 0, 0, 1, 32'hDEADBEEF, 0, "R6 post");
    cycle(0, 0, 0, 0, 0, 0, 0, 1, 32'h12345678, 0, "R6 reject");
    hr(4'd15, "R6 icm"); hr(4'd12, "R6 icm");
    hw(4'd2, 8'hFF, "R5 hmask"); hr(4'd2, "R5 hmask rd"); hr(4'd3, "R8 irq");
    hw(4'd3, 8'h00, "R5 w0"); hw(4'd3, 8'h01, "R5 w1c"); hr(4'd3, "R5 rd");
    // R7 raise vs clear
    cycle(1, 4'd3, 8'h80, 0, 0, 0, 0, 0, 0, 1, "R7 raise wins");
    hr(4'd3, "R7 rd");
    hw(4'd2, 8'h00, "R8 unmask"); hr(4'd3, "R8 off");
    // random phase
    for (int k = 0; k < 4000; k++) begin
      logic [3:0] a;
      logic [7:0] d;
      a = 4'($urandom_range(0, 15));
      d = 8'($urandom);
      if (a == 4'd0 && $urandom_range(0, 3) != 0) d = d | 8'hE1;
      cycle($urandom_range(0, 2) == 0, a, d, $urandom_range(0, 3) != 0,
            $urandom_range(0, 5) == 0, $urandom_range(0, 5) == 0, $urandom_range(0, 5) == 0,
            $urandom_range(0, 4) == 0, $urandom, $urandom_range(0, 6) == 0, "R11 rand");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule